// File: doc/BRIEF.md
# Prescaled Timebase Counter Set

This block is a small timebase peripheral that sits on a plain 32-bit register bus. It holds four counters and one reload register. A 32-bit prescale down-counter counts toward zero. On each clock where it sits at zero, it steps a 32-bit cycle up-counter, and it then restarts from a software-held reload value. Beside it run two free-running 32-bit counters. One advances once per second and the other a hundred times per second. Their ticks come from internal dividers sized by the `CLK_FREQ_HZ` parameter.

Every counter can be read and written, so software can preset or clear a counter at any time. The bus has no back-pressure. A write is taken in the clock where `bus_sel` and `bus_write` are both high, and a read is answered combinationally in the same cycle. Only the five mapped byte offsets are decoded. Every other address reads as zero and ignores writes.

Top module: `timebase_counters`

## Requirements
- R1: Byte offsets are decoded in full. 0x10 is the seconds counter, 0x14 the centisecond counter, 0x18 the cycle counter, 0x20 the prescale reload value and 0x24 the live prescale count. While `bus_sel` is high and `bus_write` is low, `bus_rdata` shows the addressed register in the same cycle.
- R2: While the prescale count is non-zero and not being written, it drops by one each clock.
- R3: In each clock where the prescale count is zero, the cycle counter rises by one. When the count is non-zero, the cycle counter holds.
- R4: In each clock where the prescale count is zero and not being written, the count takes the reload value on the next edge.
- R5: With a reload value of zero, the cycle counter rises on every clock.
- R6: A bus write to a counter or to the prescale count wins over the hardware step or reload in the same clock. The written value appears on the next edge.
- R7: The centisecond counter rises once every `CLK_FREQ_HZ/100` clocks. The seconds counter rises once every `CLK_FREQ_HZ` clocks. Each counter gets exactly one tick per period, counted from reset.
- R8: Reset (`rst_n` low) clears every counter, the reload value and both dividers to zero.
- R9: All counters wrap from 0xFFFFFFFF to 0.
- R10: Reads at an unmapped offset, or with `bus_sel` low, return zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |

## Verification
A wrong prescale count or a wrong reload value shows up two ways. It is visible at offset 0x24 in the very next read. It also shows up as a cycle counter at 0x18 that steps at the wrong interval, within one reload period. A divider that drifts or double-ticks puts the centisecond counter out of step with the reference model within one divider period. A write that loses its priority over the hardware shows a value off by one in the cycle after the write. The bench sweeps addresses continually and compares every read against a behavioural model on every clock, so each such error is caught within a cycle of becoming visible.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [7:0] OFS_SEC   = 8'h10;
  localparam logic [7:0] OFS_CSEC  = 8'h14;
  localparam logic [7:0] OFS_CYC   = 8'h18;
  localparam logic [7:0] OFS_RLD   = 8'h20;
  localparam logic [7:0] OFS_PSC   = 8'h24;
  localparam int unsigned N_UPCNT  = 3;
  typedef enum logic [1:0] {UC_SEC = 2'd0, UC_CSEC = 2'd1, UC_CYC = 2'd2} upcnt_e;
endpackage

// File: rtl/timebase_tick_div.sv
module timebase_tick_div #(
  parameter int unsigned PERIOD = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  generate
    if (PERIOD <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt;
      localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
      assign tick = (cnt == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else if (tick) cnt <= '0;
        else cnt <= cnt + CW'(1);
      end

      p_single_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
      p_div_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> cnt == $past(cnt) + CW'(1));
    end
  endgenerate
endmodule

// File: rtl/timebase_up_counter.sv
module timebase_up_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (wr_en) q <= wr_data;
    else if (inc) q <= q + W'(1);
  end

  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wr_data));
  p_step_wraps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && inc) |=> q == $past(q) + W'(1));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !inc) |=> $stable(q));
endmodule

// File: rtl/timebase_prescaler.sv
module timebase_prescaler #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rld_wr,
  input  logic         cnt_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         at_zero
);
  assign at_zero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload <= '0;
    else if (rld_wr) reload <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (cnt_wr) count <= wr_data;
    else if (at_zero) count <= reload;
    else count <= count - W'(1);
  end

  p_down_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && count != '0) |=> count == $past(count) - W'(1));
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && count == '0) |=> count == $past(reload));
  p_count_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(wr_data));
endmodule

// File: rtl/timebase_counters.sv
module timebase_counters
  import timebase_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int unsigned SEC_PERIOD  = CLK_FREQ_HZ;
  localparam int unsigned CSEC_PERIOD = (CLK_FREQ_HZ / 100 > 0) ? CLK_FREQ_HZ / 100 : 1;

  logic wr;
  logic [DATA_W-1:0] cnt_q [N_UPCNT];
  logic [N_UPCNT-1:0] cnt_wr, cnt_inc;
  logic tick_sec, tick_csec;
  logic rld_wr, psc_wr, psc_zero;
  logic [DATA_W-1:0] rld_q, psc_q;

  assign wr = bus_sel && bus_write;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign cnt_wr[UC_SEC]  = wr && hit(bus_addr, OFS_SEC);
  assign cnt_wr[UC_CSEC] = wr && hit(bus_addr, OFS_CSEC);
  assign cnt_wr[UC_CYC]  = wr && hit(bus_addr, OFS_CYC);
  assign rld_wr          = wr && hit(bus_addr, OFS_RLD);
  assign psc_wr          = wr && hit(bus_addr, OFS_PSC);

  assign cnt_inc[UC_SEC]  = tick_sec;
  assign cnt_inc[UC_CSEC] = tick_csec;
  assign cnt_inc[UC_CYC]  = psc_zero;

  timebase_tick_div #(.PERIOD(SEC_PERIOD)) u_div_sec (
    .clk(clk), .rst_n(rst_n), .tick(tick_sec));
  timebase_tick_div #(.PERIOD(CSEC_PERIOD)) u_div_csec (
    .clk(clk), .rst_n(rst_n), .tick(tick_csec));

  timebase_prescaler #(.W(DATA_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .rld_wr(rld_wr), .cnt_wr(psc_wr),
    .wr_data(bus_wdata), .reload(rld_q), .count(psc_q), .at_zero(psc_zero));

  generate
    for (genvar i = 0; i < N_UPCNT; i++) begin : g_cnt
      timebase_up_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_en(cnt_wr[i]), .wr_data(bus_wdata),
        .inc(cnt_inc[i]), .q(cnt_q[i]));
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_write) begin
      if (hit(bus_addr, OFS_SEC))       bus_rdata = cnt_q[UC_SEC];
      else if (hit(bus_addr, OFS_CSEC)) bus_rdata = cnt_q[UC_CSEC];
      else if (hit(bus_addr, OFS_CYC))  bus_rdata = cnt_q[UC_CYC];
      else if (hit(bus_addr, OFS_RLD))  bus_rdata = rld_q;
      else if (hit(bus_addr, OFS_PSC))  bus_rdata = psc_q;
    end
  end

  p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata == '0);
  p_cycle_follows_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (psc_q == '0 && !cnt_wr[UC_CYC]) |=> cnt_q[UC_CYC] == $past(cnt_q[UC_CYC]) + 32'd1);
  p_one_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_wr, rld_wr, psc_wr}));
endmodule

// File: tb/timebase_counters_tb.sv
module timebase_counters_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FREQ = 1000;
  localparam int P_SEC = FREQ;
  localparam int P_CSEC = FREQ / 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // reference model state
  int unsigned m_sec = 0, m_csec = 0, m_cyc = 0, m_rld = 0, m_psc = 0;
  int unsigned d_sec = 0, d_csec = 0;
  string cur_tag = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;

  timebase_counters #(.CLK_FREQ_HZ(FREQ), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, bus_addr, got, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic sel, input logic w, input logic [7:0] a);
    if (!sel || w) return 32'h0;
    case (a)
      8'h10: return m_sec;
      8'h14: return m_csec;
      8'h18: return m_cyc;
      8'h20: return m_rld;
      8'h24: return m_psc;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void m_advance(input logic w, input logic [7:0] a, input logic [31:0] d);
    bit ts = (d_sec == P_SEC - 1);
    bit tc = (d_csec == P_CSEC - 1);
    bit z  = (m_psc == 0);
    d_sec  = ts ? 0 : d_sec + 1;
    d_csec = tc ? 0 : d_csec + 1;
    if (w && a == 8'h10) m_sec = d; else if (ts) m_sec = m_sec + 1;
    if (w && a == 8'h14) m_csec = d; else if (tc) m_csec = m_csec + 1;
    if (w && a == 8'h18) m_cyc = d; else if (z) m_cyc = m_cyc + 1;
    if (w && a == 8'h24) m_psc = d; else if (z) m_psc = m_rld; else m_psc = m_psc - 1;
    if (w && a == 8'h20) m_rld = d;
  endfunction

  // called at a negedge: check what is presented, then present the next access
  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input string tag);
    check(cur_tag, bus_rdata, m_read(bus_sel, bus_write, bus_addr));
    bus_sel = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    cur_tag = tag;
    m_advance(w, a, d);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, a, 32'h0, tag);
  endtask

  task automatic wrt(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1'b1, a, d, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R8: reset state, read combinationally while held in reset
    @(negedge clk);
    foreach (u_addr_list[i]) begin end
    for (int i = 0; i < 5; i++) begin
      bus_sel = 1'b1; bus_write = 1'b0;
      bus_addr = (i < 3) ? 8'(8'h10 + 4*i) : 8'(8'h20 + 4*(i-3));
      @(negedge clk);
      check("R8", bus_rdata, 32'h0);
    end
    bus_addr = 8'h18;
    rst_n = 1'b1;
    cur_tag = "R5";
    // R5: reload zero, cycle counter steps every clock
    for (int i = 0; i < 8; i++) rd(8'h18, "R5");
    // R4 / R2: reload of 3, observe count and cycle counter
    wrt(8'h20, 32'd3, "R1");
    for (int i = 0; i < 12; i++) rd(8'h24, "R2");
    for (int i = 0; i < 12; i++) rd(8'h18, "R3");
    rd(8'h20, "R1");
    for (int i = 0; i < 8; i++) rd(8'h24, "R4");
    // R6: writes collide with hardware steps
    for (int i = 0; i < 6; i++) begin
      wrt(8'h24, 32'd0, "R6");
      wrt(8'h18, 32'd100 + i, "R6");
      rd(8'h18, "R6");
      rd(8'h24, "R6");
    end
    wrt(8'h14, 32'h55, "R6");
    rd(8'h14, "R6");
    // R9: wrap
    wrt(8'h20, 32'd0, "R9");
    wrt(8'h18, 32'hFFFF_FFFE, "R9");
    for (int i = 0; i < 4; i++) rd(8'h18, "R9");
    wrt(8'h14, 32'hFFFF_FFFF, "R9");
    for (int i = 0; i < 25; i++) rd(8'h14, "R9");
    // R10: unmapped offsets
    wrt(8'h1C, 32'hDEAD_BEEF, "R10");
    wrt(8'h00, 32'h1234_5678, "R10");
    wrt(8'h28, 32'h1, "R10");
    rd(8'h1C, "R10"); rd(8'h00, "R10"); rd(8'h28, "R10"); rd(8'h11, "R10");
    rd(8'h18, "R10"); rd(8'h24, "R10");
    check("R10", bus_rdata, m_read(bus_sel, bus_write, bus_addr));
    bus_sel = 1'b0;
    @(negedge clk);
    check("R10", bus_rdata, 32'h0);
    m_advance(1'b0, 8'h00, 32'h0);
    bus_sel = 1'b1; bus_addr = 8'h10; cur_tag = "R7";
    // R7: long run with address sweep, reload 7
    wrt(8'h20, 32'd7, "R4");
    for (int i = 0; i < 2600; i++) begin
      case (i % 5)
        0: rd(8'h10, "R7");
        1: rd(8'h14, "R7");
        2: rd(8'h18, "R3");
        3: rd(8'h24, "R2");
        default: rd(8'h20, "R1");
      endcase
      if (i % 397 == 0) wrt(8'h10, 32'(i), "R6");
    end
    rd(8'h10, "R7");
    check(cur_tag, bus_rdata, m_read(bus_sel, bus_write, bus_addr));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int u_addr_list[1] = '{0};
endmodule